// File: doc/BRIEF.md
# Stage-1 Access Permission Checker

This block decides whether one memory access may proceed, given the permission attributes held in a stage-1 translation entry and the state of the requesting context. It takes the entry's two-bit access-protection code, its execute-never and privileged-execute-never bits, a write-implies-no-execute control, the current exception level with its privilege qualifiers, the security context and the kind of access. It returns a single grant bit plus the read permission that applies to the requester.

Decoding runs in three steps. First the effective level and the regime kind are found. Two regime kinds exist: `RGM_SPLIT` has both a privileged and an unprivileged half, and `RGM_SINGLE` has only one privilege. Next the entry's fields are turned into read, write and execute permissions. Last come the execute restrictions, and one permission is picked by access-type priority. The result is captured in output registers. `out_valid` rises one clock after `in_valid`, and when `in_valid` is low the outputs hold their last value.

Top module: `s1_perm_gate`

## Requirements
- R1: A request is privileged only when `priv_flag`=1 and `user_ovr`=0. Any other request is evaluated at level 0, whatever `el` says.
- R2: The regime is `RGM_SPLIT` when the effective level is 0 or 1, or when it is 2 with `host_ext`=1. At level 2 with `host_ext`=0, and always at level 3, the regime is `RGM_SINGLE`.
- R3: In `RGM_SPLIT`, the privileged (P) and unprivileged (U) rights per `ap` are: `ap`=0 gives P read/write and no U access; `ap`=1 gives read/write to both; `ap`=2 gives P read only; `ap`=3 gives read only to both. The requester's own half is the one used.
- R4: In `RGM_SPLIT`, privileged execute needs `pxn`=0 and no unprivileged write right (so `ap`=1 is never privileged-executable). Unprivileged execute needs `xn`=0.
- R5: In `RGM_SINGLE`, `ap[1]`=0 means read/write and `ap[1]`=1 means read only. `ap[0]` has no effect. Execute needs `xn`=0.
- R6: When `wxn`=1 and write permission holds, execute permission is removed.
- R7: When `el3_present`, `sec_state`, `entry_ns` and `sec_fetch_lock` are all 1, execute is denied.
- R8: The grant is chosen by priority: `acc_ex` uses execute permission; otherwise `acc_atomic` needs both read and write; otherwise `acc_wr` uses write; otherwise read permission is used.
- R9: `rd_perm` always carries the requester's read permission, for every access type.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. `grant` and `rd_perm` update only on a cycle where `in_valid`=1, and hold otherwise.
- R11: A synchronous reset `rst` drives `out_valid`, `grant` and `rd_perm` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| ap | input | 2 | Access-protection code of the entry |
| xn | input | 1 | Execute-never bit |
| pxn | input | 1 | Privileged-execute-never bit |
| wxn | input | 1 | Write-implies-no-execute control |
| el | input | 2 | Current exception level |
| priv_flag | input | 1 | Request marked privileged |
| user_ovr | input | 1 | Forces unprivileged treatment |
| host_ext | input | 1 | Gives level 2 an unprivileged half |
| sec_state | input | 1 | Requester in secure state |
| entry_ns | input | 1 | Entry maps non-secure memory |
| sec_fetch_lock | input | 1 | Blocks secure fetch from non-secure memory |
| el3_present | input | 1 | Level 3 is implemented |
| acc_rd | input | 1 | Read access |
| acc_wr | input | 1 | Write access |
| acc_ex | input | 1 | Instruction fetch |
| acc_atomic | input | 1 | Read-modify-write access |
| out_valid | output | 1 | Result strobe |
| grant | output | 1 | Access allowed |
| rd_perm | output | 1 | Read permission of the requester |

## Verification
The hardest case to reach from the ports is the level-2 regime with its unprivileged half enabled. It needs a privileged request with no user override, `el`=2 and `host_ext`=1. Only then does the split table with the privileged-execute block for `ap`=1 apply at level 2. Directed vectors drive that combination, and the same entry with `host_ext`=0 and at level 3, so the two regime kinds can be compared. Seeded random vectors then cover the mixed access-type bits and the secure-fetch and write-implies-no-execute overlaps.

// File: rtl/s1pg_pkg.sv
package s1pg_pkg;
    localparam int LVL_W = 2;
    localparam int AP_W  = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } exc_level_e;

    typedef enum logic {
        RGM_SINGLE = 1'b0,
        RGM_SPLIT  = 1'b1
    } regime_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;
endpackage

// File: rtl/s1pg_regime.sv
module s1pg_regime
    import s1pg_pkg::*;
(
    input  logic [LVL_W-1:0] el,
    input  logic             priv_flag,
    input  logic             user_ovr,
    input  logic             host_ext,
    output logic             is_priv,
    output regime_e          regime
);
    exc_level_e eff_level;

    always_comb begin
        is_priv   = priv_flag && !user_ovr;
        eff_level = is_priv ? exc_level_e'(el) : LVL0;
    end

    always_comb begin
        unique case (eff_level)
            LVL0, LVL1: regime = RGM_SPLIT;
            LVL2:       regime = host_ext ? RGM_SPLIT : RGM_SINGLE;
            LVL3:       regime = RGM_SINGLE;
            default:    regime = RGM_SINGLE;
        endcase
    end
endmodule

// File: rtl/s1pg_perm_table.sv
module s1pg_perm_table
    import s1pg_pkg::*;
(
    input  logic [AP_W-1:0] ap,
    input  logic            xn,
    input  logic            pxn,
    input  logic            is_priv,
    input  regime_e         regime,
    output perm_t           perm
);
    logic p_rd, p_wr, u_rd, u_wr, p_ex, u_ex;

    always_comb begin
        p_rd = 1'b1;
        unique case (ap)
            2'b00: begin p_wr = 1'b1; u_rd = 1'b0; u_wr = 1'b0; end
            2'b01: begin p_wr = 1'b1; u_rd = 1'b1; u_wr = 1'b1; end
            2'b10: begin p_wr = 1'b0; u_rd = 1'b0; u_wr = 1'b0; end
            2'b11: begin p_wr = 1'b0; u_rd = 1'b1; u_wr = 1'b0; end
            default: begin p_wr = 1'b0; u_rd = 1'b0; u_wr = 1'b0; end
        endcase
        p_ex = !(pxn || u_wr);
        u_ex = !xn;
    end

    always_comb begin
        unique case (regime)
            RGM_SPLIT: begin
                perm.rd = is_priv ? p_rd : u_rd;
                perm.wr = is_priv ? p_wr : u_wr;
                perm.ex = is_priv ? p_ex : u_ex;
            end
            RGM_SINGLE: begin
                perm.rd = 1'b1;
                perm.wr = !ap[AP_W-1];
                perm.ex = !xn;
            end
            default: perm = '0;
        endcase
    end
endmodule

// File: rtl/s1pg_grant_sel.sv
module s1pg_grant_sel
    import s1pg_pkg::*;
(
    input  perm_t perm,
    input  logic  wxn,
    input  logic  el3_present,
    input  logic  sec_state,
    input  logic  entry_ns,
    input  logic  sec_fetch_lock,
    input  logic  acc_wr,
    input  logic  acc_ex,
    input  logic  acc_atomic,
    output logic  ex_final,
    output logic  grant_c
);
    logic fetch_blocked;

    always_comb begin
        fetch_blocked = el3_present && sec_state && entry_ns && sec_fetch_lock;
        ex_final      = perm.ex && !(wxn && perm.wr) && !fetch_blocked;
        if (acc_ex)          grant_c = ex_final;
        else if (acc_atomic) grant_c = perm.rd && perm.wr;
        else if (acc_wr)     grant_c = perm.wr;
        else                 grant_c = perm.rd;
    end
endmodule

// File: rtl/s1_perm_gate.sv
module s1_perm_gate
    import s1pg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [AP_W-1:0]  ap,
    input  logic             xn,
    input  logic             pxn,
    input  logic             wxn,
    input  logic [LVL_W-1:0] el,
    input  logic             priv_flag,
    input  logic             user_ovr,
    input  logic             host_ext,
    input  logic             sec_state,
    input  logic             entry_ns,
    input  logic             sec_fetch_lock,
    input  logic             el3_present,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic             acc_ex,
    input  logic             acc_atomic,
    output logic             out_valid,
    output logic             grant,
    output logic             rd_perm
);
    logic    is_priv;
    regime_e regime;
    perm_t   perm;
    logic    ex_final;
    logic    grant_c;
    logic    rd_unused;

    assign rd_unused = acc_rd;

    s1pg_regime u_regime (
        .el        (el),
        .priv_flag (priv_flag),
        .user_ovr  (user_ovr),
        .host_ext  (host_ext),
        .is_priv   (is_priv),
        .regime    (regime)
    );

    s1pg_perm_table u_table (
        .ap      (ap),
        .xn      (xn),
        .pxn     (pxn),
        .is_priv (is_priv),
        .regime  (regime),
        .perm    (perm)
    );

    s1pg_grant_sel u_sel (
        .perm           (perm),
        .wxn            (wxn),
        .el3_present    (el3_present),
        .sec_state      (sec_state),
        .entry_ns       (entry_ns),
        .sec_fetch_lock (sec_fetch_lock),
        .acc_wr         (acc_wr),
        .acc_ex         (acc_ex),
        .acc_atomic     (acc_atomic),
        .ex_final       (ex_final),
        .grant_c        (grant_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            grant     <= 1'b0;
            rd_perm   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                grant   <= grant_c;
                rd_perm <= perm.rd;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && !grant && !rd_perm)); // R11
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(grant) && $stable(rd_perm))); // R10
    AST_UWRITE_NO_PEXEC: assert property (@(posedge clk) disable iff (rst)
        (regime == RGM_SPLIT && is_priv && ap == 2'b01) |-> !ex_final); // R4
    AST_WXN_NO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (wxn && perm.wr) |-> !ex_final); // R6
    AST_SEC_FETCH_DENY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_ex && el3_present && sec_state && entry_ns && sec_fetch_lock)
        |=> !grant); // R7
    AST_EXEC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_ex) |=> (grant == $past(ex_final))); // R8
    AST_UNPRIV_SPLIT: assert property (@(posedge clk) disable iff (rst)
        !is_priv |-> (regime == RGM_SPLIT)); // R1
endmodule

// File: tb/tb_s1_perm_gate.sv
module tb_s1_perm_gate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] ap = '0;
    logic xn = 0, pxn = 0, wxn = 0;
    logic [1:0] el = '0;
    logic priv_flag = 0, user_ovr = 0, host_ext = 0;
    logic sec_state = 0, entry_ns = 0, sec_fetch_lock = 0, el3_present = 0;
    logic acc_rd = 0, acc_wr = 0, acc_ex = 0, acc_atomic = 0;
    logic out_valid, grant, rd_perm;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    s1_perm_gate dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ap(ap), .xn(xn), .pxn(pxn),
        .wxn(wxn), .el(el), .priv_flag(priv_flag), .user_ovr(user_ovr),
        .host_ext(host_ext), .sec_state(sec_state), .entry_ns(entry_ns),
        .sec_fetch_lock(sec_fetch_lock), .el3_present(el3_present),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_ex(acc_ex), .acc_atomic(acc_atomic),
        .out_valid(out_valid), .grant(grant), .rd_perm(rd_perm)
    );

    // Expected {grant, read} from the requirement text.
    function automatic logic [1:0] model();
        logic pv, split, r, w, x, uw;
        logic [1:0] lvl;
        pv    = priv_flag && !user_ovr;                    // R1
        lvl   = pv ? el : 2'd0;
        split = (lvl <= 2'd1) || (lvl == 2'd2 && host_ext); // R2
        if (split) begin                                   // R3, R4
            uw = (ap == 2'b01);
            r  = pv ? 1'b1 : ap[0];
            w  = pv ? !ap[1] : uw;
            x  = pv ? !(pxn || uw) : !xn;
        end else begin                                     // R5
            r = 1'b1; w = !ap[1]; x = !xn;
        end
        if (wxn && w) x = 1'b0;                            // R6
        if (el3_present && sec_state && entry_ns && sec_fetch_lock) x = 1'b0; // R7
        if (acc_ex)          return {x, r};                // R8
        else if (acc_atomic) return {r && w, r};
        else if (acc_wr)     return {w, r};
        else                 return {r, r};
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Apply the current inputs with in_valid high and check one cycle later.
    task automatic run(input string tag);
        logic [1:0] e;
        e = model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid, 1'b1, "R10 valid");
        check(grant, e[1], tag);
        check(rd_perm, e[0], {tag, " R9 rd_perm"});
    endtask

    task automatic clear_inputs();
        ap = 0; xn = 0; pxn = 0; wxn = 0; el = 0; priv_flag = 0; user_ovr = 0;
        host_ext = 0; sec_state = 0; entry_ns = 0; sec_fetch_lock = 0;
        el3_present = 0; acc_rd = 0; acc_wr = 0; acc_ex = 0; acc_atomic = 0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<50000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic g0, r0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(out_valid, 1'b0, "R11 reset valid");
        check(grant, 1'b0, "R11 reset grant");
        check(rd_perm, 1'b0, "R11 reset rd_perm");
        rst = 1'b0;
        @(negedge clk);

        // R3: unprivileged read of ap=0 denied; privileged read allowed
        clear_inputs(); el = 1; acc_rd = 1; run("R3 ap0 unpriv read");
        priv_flag = 1; run("R3 ap0 priv read");
        ap = 2'b10; acc_rd = 0; acc_wr = 1; run("R3 ap2 priv write");
        priv_flag = 0; ap = 2'b11; run("R3 ap3 unpriv write");
        // R1: user override forces level-0 treatment
        clear_inputs(); el = 3; priv_flag = 1; user_ovr = 1; acc_rd = 1; run("R1 user override");
        // R4: privileged exec blocked by unprivileged write right
        clear_inputs(); el = 1; priv_flag = 1; ap = 2'b01; acc_ex = 1; run("R4 uw blocks pexec");
        ap = 2'b00; run("R4 pexec ok");
        ap = 2'b11; priv_flag = 0; xn = 1; run("R4 uexec xn");
        // R2: level 2 with and without host extension, level 3
        clear_inputs(); el = 2; priv_flag = 1; ap = 2'b01; acc_ex = 1; host_ext = 1;
        run("R2 lvl2 split"); check(grant, 1'b0, "R2 lvl2 split denies");
        host_ext = 0; run("R2 lvl2 single"); check(grant, 1'b1, "R2 lvl2 single allows");
        el = 3; host_ext = 1; run("R2 lvl3 single");
        // R5: ap[0] ignored in single regime
        clear_inputs(); el = 3; priv_flag = 1; acc_wr = 1; ap = 2'b01; run("R5 ap1 write");
        ap = 2'b10; run("R5 ap2 write");
        // R6
        clear_inputs(); el = 3; priv_flag = 1; acc_ex = 1; wxn = 1; run("R6 wxn writable");
        ap = 2'b10; run("R6 wxn readonly");
        // R7
        clear_inputs(); el = 3; priv_flag = 1; acc_ex = 1; el3_present = 1; sec_state = 1;
        entry_ns = 1; sec_fetch_lock = 1; run("R7 sec fetch lock");
        el3_present = 0; run("R7 no level3");
        // R8: exec wins over write; atomic needs both
        clear_inputs(); el = 3; priv_flag = 1; ap = 2'b10; acc_wr = 1; acc_ex = 1; run("R8 exec over write");
        acc_ex = 0; acc_atomic = 1; run("R8 atomic ro");
        check(grant, 1'b0, "R8 atomic denied"); check(rd_perm, 1'b1, "R9 rd on atomic");
        // R10: idle cycle holds outputs
        g0 = grant; r0 = rd_perm;
        ap = 2'b00; acc_atomic = 0; acc_rd = 1;
        @(negedge clk);
        check(out_valid, 1'b0, "R10 idle valid");
        check(grant, g0, "R10 hold grant");
        check(rd_perm, r0, "R10 hold rd_perm");

        // random
        for (int i = 0; i < 3000; i++) begin
            {ap, xn, pxn, wxn, el} = 7'($urandom);
            {priv_flag, user_ovr, host_ext, sec_state, entry_ns} = 5'($urandom);
            {sec_fetch_lock, el3_present, acc_rd, acc_wr, acc_ex, acc_atomic} = 6'($urandom);
            run("R8 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule